// File: doc/BRIEF.md
# PCI Target Parity Generator and Checker

This block sits beside the bus state machine of a 32-bit PCI target and handles everything to do with bus parity. It follows the shared address/data lines, the command/byte-enable lines and the framing and handshake strobes cycle by cycle. From these it works out which clock is an address phase, which clocks carry read data driven by this target, and which clocks complete a write data phase that this target has claimed.

For read data it produces the parity bit one clock behind the data, together with an output enable. For address phases and completed write data phases it compares the parity bit supplied by the master, again one clock late. A bad data phase is reported on a sustained-tristate error line. A bad address phase is reported on an open-drain style system error line. Each pad is modelled as a drive value plus an output enable. A sticky status bit records every mismatch found, and software clears it with a write-one-to-clear strobe.

The target state machine supplies the claim flag and the transfer direction. Two enable inputs gate the two error lines separately.

Top module: `pci_par_unit`

## Requirements
- R1: During every data-phase clock of a read that this target has claimed with DEVSEL low, the parity output is enabled one clock later. Its value makes the XOR of the 32 AD bits, the 4 C/BE bits and the parity bit equal 0 (even parity). This includes the clock after the last completed read phase.
- R2: The parity output enable stays low in the clock after an address phase, after any write data phase, after any unclaimed read phase, and after an idle clock.
- R3: An address phase is a clock with FRAME low where the previous clock had both FRAME and IRDY high. If the parity sampled in the next clock breaks even parity of that phase and the system-error enable is high, the system error line is driven low for exactly one clock, in the second clock after the address phase.
- R4: The system error line is never driven high. Whenever its enable is on its value is 0, and it returns to undriven by dropping the enable.
- R5: A data phase completes on a clock with IRDY, TRDY and DEVSEL all low. If a completed write phase claimed by this target is followed by a parity bit that breaks even parity and the parity-error enable is high, the parity error line is driven low in the second clock after that phase.
- R6: After its last low clock, the parity error line is driven high for one clock and then released.
- R7: Wait-state clocks (TRDY high) and phases that are not claimed never cause a parity error report, and they do not set the status bit.
- R8: The status bit is set one clock after any address-phase or claimed-write-phase mismatch, even when reporting is disabled. It stays set until the clear strobe is high. If a new mismatch and the clear strobe arrive in the same clock, the bit stays set.
- R9: While reset is high, all three output enables and the status bit are 0, and both error values read 1.
- R10: Phases with correct even parity produce no error report and leave the status bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ad_i | input | 32 | Address/data lines as seen on the bus |
| cbe_n_i | input | 4 | Command / byte-enable lines (active low) |
| par_i | input | 1 | Parity line as seen on the bus |
| frame_n_i | input | 1 | Cycle frame, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| devsel_n_i | input | 1 | Device select, active low |
| rd_dir_i | input | 1 | 1 when the current transaction is a read |
| claimed_i | input | 1 | Target state machine owns the current transaction |
| perr_en_i | input | 1 | Allows parity error reporting |
| serr_en_i | input | 1 | Allows system error reporting |
| stat_clr_i | input | 1 | Write-one-to-clear strobe for the status bit |
| par_o | output | 1 | Parity value driven for read data |
| par_oe_o | output | 1 | Output enable of the parity pad |
| perr_n_o | output | 1 | Parity error drive value |
| perr_oe_o | output | 1 | Parity error pad enable |
| serr_n_o | output | 1 | System error drive value |
| serr_oe_o | output | 1 | System error pad enable |
| par_err_stat_o | output | 1 | Sticky parity-mismatch status |

## Verification
The assertions assume a legal bus. Address phases are always preceded by a clock with FRAME and IRDY both high. The target's claim and direction flags stay steady through a transaction. The bench drives only whole transactions of that form: an address clock, data clocks with optional wait states, and a turnaround clock with every strobe high, separated by idle clocks. It changes the enables and the clear strobe only at clock boundaries it plans ahead. Corrupt parity is injected only as a flipped parity bit, so the framing never leaves the legal protocol.

// File: rtl/pci_par_pkg.sv
`timescale 1ns/1ps
package pci_par_pkg;

  // Per-clock decode of the bus strobes
  typedef struct packed {
    logic addr_phase;  // first clock of a transaction
    logic wr_done;     // claimed write data phase completes
    logic rd_win;      // claimed read data clock, target drives AD
  } phase_t;

endpackage

// File: rtl/pci_par_tree.sv
`timescale 1ns/1ps
module pci_par_tree #(
  parameter int AD_W  = 32,
  parameter int CBE_W = AD_W / 8
) (
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_n_i,
  output logic             even_par_o
);
  localparam int LANE_W = AD_W / CBE_W;

  logic [CBE_W-1:0] lane_par;

  // One XOR per byte lane including its enable bit, then fold the lanes
  for (genvar g = 0; g < CBE_W; g++) begin : g_lane
    assign lane_par[g] = (^ad_i[g*LANE_W +: LANE_W]) ^ cbe_n_i[g];
  end

  assign even_par_o = ^lane_par;
endmodule

// File: rtl/pci_par_phase.sv
`timescale 1ns/1ps
module pci_par_phase
  import pci_par_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   frame_n_i,
  input  logic   irdy_n_i,
  input  logic   trdy_n_i,
  input  logic   devsel_n_i,
  input  logic   rd_dir_i,
  input  logic   claimed_i,
  output phase_t phase_o
);
  logic prev_idle_q;
  logic idle_now;
  logic data_cyc;
  logic owned;

  always_ff @(posedge clk) begin
    if (rst) prev_idle_q <= 1'b1;
    else     prev_idle_q <= frame_n_i & irdy_n_i;
  end

  assign idle_now = frame_n_i & irdy_n_i;
  assign data_cyc = ~prev_idle_q & ~idle_now;
  assign owned    = claimed_i & ~devsel_n_i;

  always_comb begin
    phase_o.addr_phase = prev_idle_q & ~frame_n_i;
    phase_o.wr_done    = data_cyc & owned & ~rd_dir_i & ~irdy_n_i & ~trdy_n_i;
    phase_o.rd_win     = data_cyc & owned & rd_dir_i;
  end
endmodule

// File: rtl/pci_par_drive.sv
`timescale 1ns/1ps
module pci_par_drive
  import pci_par_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase_i,
  input  logic   even_par_i,
  output logic   par_o,
  output logic   par_oe_o
);
  // PAR trails AD by exactly one clock, so one register stage is enough
  always_ff @(posedge clk) begin
    if (rst) begin
      par_o    <= 1'b0;
      par_oe_o <= 1'b0;
    end else begin
      par_o    <= phase_i.rd_win ? even_par_i : 1'b0;
      par_oe_o <= phase_i.rd_win;
    end
  end
endmodule

// File: rtl/pci_par_check.sv
`timescale 1ns/1ps
module pci_par_check
  import pci_par_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase_i,
  input  logic   even_par_i,
  input  logic   par_i,
  output logic   addr_err_o,
  output logic   data_err_o
);
  logic addr_pend_q, addr_exp_q;
  logic data_pend_q, data_exp_q;

  // Keep the expected bit; the master's PAR shows up one clock later
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_pend_q <= 1'b0;
      addr_exp_q  <= 1'b0;
      data_pend_q <= 1'b0;
      data_exp_q  <= 1'b0;
    end else begin
      addr_pend_q <= phase_i.addr_phase;
      data_pend_q <= phase_i.wr_done;
      if (phase_i.addr_phase) addr_exp_q <= even_par_i;
      if (phase_i.wr_done)    data_exp_q <= even_par_i;
    end
  end

  assign addr_err_o = addr_pend_q & (par_i != addr_exp_q);
  assign data_err_o = data_pend_q & (par_i != data_exp_q);
endmodule

// File: rtl/pci_par_report.sv
`timescale 1ns/1ps
module pci_par_report (
  input  logic clk,
  input  logic rst,
  input  logic addr_err_i,
  input  logic data_err_i,
  input  logic perr_en_i,
  input  logic serr_en_i,
  input  logic stat_clr_i,
  output logic perr_n_o,
  output logic perr_oe_o,
  output logic serr_n_o,
  output logic serr_oe_o,
  output logic stat_o
);
  logic fire_p, fire_s;

  assign fire_p = data_err_i & perr_en_i;
  assign fire_s = addr_err_i & serr_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      perr_n_o  <= 1'b1;
      perr_oe_o <= 1'b0;
      serr_n_o  <= 1'b1;
      serr_oe_o <= 1'b0;
      stat_o    <= 1'b0;
    end else begin
      // Sustained tristate: a low clock is followed by one high clock
      perr_n_o  <= ~fire_p;
      perr_oe_o <= fire_p | (perr_oe_o & ~perr_n_o);
      // Open drain: only ever pulled low, for one clock
      serr_n_o  <= ~fire_s;
      serr_oe_o <= fire_s;
      // New mismatch wins over a clear in the same clock
      stat_o    <= (stat_o & ~stat_clr_i) | addr_err_i | data_err_i;
    end
  end
endmodule

// File: rtl/pci_par_unit.sv
`timescale 1ns/1ps
module pci_par_unit
  import pci_par_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = AD_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_n_i,
  input  logic             par_i,
  input  logic             frame_n_i,
  input  logic             irdy_n_i,
  input  logic             trdy_n_i,
  input  logic             devsel_n_i,
  input  logic             rd_dir_i,
  input  logic             claimed_i,
  input  logic             perr_en_i,
  input  logic             serr_en_i,
  input  logic             stat_clr_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_n_o,
  output logic             perr_oe_o,
  output logic             serr_n_o,
  output logic             serr_oe_o,
  output logic             par_err_stat_o
);
  phase_t phase;
  logic   even_par;
  logic   addr_err, data_err;

  pci_par_tree #(.AD_W(AD_W), .CBE_W(CBE_W)) u_tree (
    .ad_i(ad_i), .cbe_n_i(cbe_n_i), .even_par_o(even_par)
  );

  pci_par_phase u_phase (
    .clk(clk), .rst(rst), .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i),
    .trdy_n_i(trdy_n_i), .devsel_n_i(devsel_n_i), .rd_dir_i(rd_dir_i),
    .claimed_i(claimed_i), .phase_o(phase)
  );

  pci_par_drive u_drive (
    .clk(clk), .rst(rst), .phase_i(phase), .even_par_i(even_par),
    .par_o(par_o), .par_oe_o(par_oe_o)
  );

  pci_par_check u_check (
    .clk(clk), .rst(rst), .phase_i(phase), .even_par_i(even_par),
    .par_i(par_i), .addr_err_o(addr_err), .data_err_o(data_err)
  );

  pci_par_report u_report (
    .clk(clk), .rst(rst), .addr_err_i(addr_err), .data_err_i(data_err),
    .perr_en_i(perr_en_i), .serr_en_i(serr_en_i), .stat_clr_i(stat_clr_i),
    .perr_n_o(perr_n_o), .perr_oe_o(perr_oe_o), .serr_n_o(serr_n_o),
    .serr_oe_o(serr_oe_o), .stat_o(par_err_stat_o)
  );
endmodule

// File: rtl/pci_par_unit_chk.sv
`timescale 1ns/1ps
module pci_par_unit_chk (
  input logic clk,
  input logic rst,
  input logic irdy_n_i,
  input logic trdy_n_i,
  input logic devsel_n_i,
  input logic rd_dir_i,
  input logic claimed_i,
  input logic perr_en_i,
  input logic serr_en_i,
  input logic stat_clr_i,
  input logic par_oe_o,
  input logic perr_n_o,
  input logic perr_oe_o,
  input logic serr_n_o,
  input logic serr_oe_o,
  input logic par_err_stat_o
);
  // R4
  serr_low_only_chk: assert property (@(posedge clk) disable iff (rst)
    serr_oe_o |-> !serr_n_o);

  // R3
  serr_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
    serr_oe_o |=> !serr_oe_o);

  // R3
  serr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    serr_oe_o |-> $past(serr_en_i));

  // R6
  perr_release_chk: assert property (@(posedge clk) disable iff (rst)
    (perr_oe_o && perr_n_o) |=> !perr_oe_o);

  // R6
  perr_high_before_off_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(perr_oe_o) |-> $past(perr_n_o));

  // R5
  perr_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (perr_oe_o && !perr_n_o) |->
      ($past(!irdy_n_i && !trdy_n_i && !devsel_n_i && claimed_i && !rd_dir_i, 2)
       && $past(perr_en_i)));

  // R1
  par_owner_chk: assert property (@(posedge clk) disable iff (rst)
    par_oe_o |-> $past(claimed_i && rd_dir_i && !devsel_n_i));

  // R8
  stat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (par_err_stat_o && !stat_clr_i) |=> par_err_stat_o);
endmodule

bind pci_par_unit pci_par_unit_chk u_chk (
  .clk(clk), .rst(rst), .irdy_n_i(irdy_n_i), .trdy_n_i(trdy_n_i),
  .devsel_n_i(devsel_n_i), .rd_dir_i(rd_dir_i), .claimed_i(claimed_i),
  .perr_en_i(perr_en_i), .serr_en_i(serr_en_i), .stat_clr_i(stat_clr_i),
  .par_oe_o(par_oe_o), .perr_n_o(perr_n_o), .perr_oe_o(perr_oe_o),
  .serr_n_o(serr_n_o), .serr_oe_o(serr_oe_o), .par_err_stat_o(par_err_stat_o)
);

// File: tb/tb_pci_par_unit.sv
`timescale 1ns/1ps
module tb_pci_par_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_n_i = '1;
  logic        par_i = 1'b0, frame_n_i = 1'b1, irdy_n_i = 1'b1;
  logic        trdy_n_i = 1'b1, devsel_n_i = 1'b1, rd_dir_i = 1'b0;
  logic        claimed_i = 1'b0, perr_en_i = 1'b1, serr_en_i = 1'b1;
  logic        stat_clr_i = 1'b0;
  logic        par_o, par_oe_o, perr_n_o, perr_oe_o, serr_n_o, serr_oe_o;
  logic        par_err_stat_o;

  pci_par_unit dut (.*);

  always #2.5 clk = ~clk;

  localparam int K_PAR_OE = 0, K_PAR = 1, K_PERR_OE = 2, K_PERR_N = 3;
  localparam int K_SERR_OE = 4, K_SERR_N = 5, K_STAT = 6;

  typedef struct { int cyc; int kind; bit val; string req; } exp_t;
  exp_t q[$];

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  int clr_cycle = -1;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit epar(logic [31:0] a, logic [3:0] c);
    return ^{a, c};
  endfunction

  function automatic bit get_out(int k);
    case (k)
      K_PAR_OE:  return par_oe_o;
      K_PAR:     return par_o;
      K_PERR_OE: return perr_oe_o;
      K_PERR_N:  return perr_n_o;
      K_SERR_OE: return serr_oe_o;
      K_SERR_N:  return serr_n_o;
      default:   return par_err_stat_o;
    endcase
  endfunction

  task automatic check(bit act, bit exp, string req, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic expect_at(int c, int k, bit v, string req);
    exp_t e;
    e.cyc = c; e.kind = k; e.val = v; e.req = req;
    q.push_back(e);
  endtask

  // Scoreboard monitor: compare every due item between clock edges
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].cyc == cyc) begin
          check(get_out(q[i].kind), q[i].val, q[i].req, $sformatf("kind%0d", q[i].kind));
          q.delete(i);
        end
      end
    end
  end

  task automatic bus(bit fr, bit ir, bit tr, bit dv, logic [31:0] a,
                     logic [3:0] c, bit p, bit rd, bit cl);
    frame_n_i = fr; irdy_n_i = ir; trdy_n_i = tr; devsel_n_i = dv;
    ad_i = a; cbe_n_i = c; par_i = p; rd_dir_i = rd; claimed_i = cl;
    stat_clr_i = (cyc + 1 == clr_cycle);
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) bus(1, 1, 1, 1, 32'h0, 4'hF, 1'b0, 1'b0, 1'b0);
  endtask

  // Write: address clock, optional waits, completing clock, turnaround
  task automatic write_txn(logic [31:0] a, logic [31:0] d, logic [3:0] be,
                           bit abad, bit dbad, bit cl, int waits);
    int sa, sc;
    bit ap, dp;
    ap = epar(a, 4'b1000) ^ abad;
    dp = epar(d, be) ^ dbad;
    sa = cyc + 1;
    expect_at(sa, K_PAR_OE, 1'b0, "R2");
    if (abad && serr_en_i) begin
      expect_at(sa + 1, K_SERR_OE, 1'b1, "R3");
      expect_at(sa + 1, K_SERR_N, 1'b0, "R4");
      expect_at(sa + 2, K_SERR_OE, 1'b0, "R3");
    end else begin
      expect_at(sa + 1, K_SERR_OE, 1'b0, abad ? "R3" : "R10");
    end
    if (abad) expect_at(sa + 1, K_STAT, 1'b1, "R8");
    bus(0, 1, 1, 1, a, 4'b1000, 1'b0, 1'b0, cl);
    for (int w = 0; w < waits; w++) begin
      expect_at(cyc + 1, K_PAR_OE, 1'b0, "R2");
      if (w > 0) expect_at(cyc + 1, K_PERR_OE, 1'b0, "R7");
      bus(1, 0, 1, 0, d, be, (w == 0) ? ap : dp, 1'b0, cl);
    end
    sc = cyc + 1;
    if (waits > 0) expect_at(sc, K_PERR_OE, 1'b0, "R7");
    expect_at(sc, K_PAR_OE, 1'b0, "R2");
    bus(1, 0, 0, 0, d, be, (waits == 0) ? ap : dp, 1'b0, cl);
    if (dbad && cl && perr_en_i) begin
      expect_at(sc + 1, K_PERR_OE, 1'b1, "R5");
      expect_at(sc + 1, K_PERR_N, 1'b0, "R5");
      expect_at(sc + 2, K_PERR_OE, 1'b1, "R6");
      expect_at(sc + 2, K_PERR_N, 1'b1, "R6");
      expect_at(sc + 3, K_PERR_OE, 1'b0, "R6");
    end else begin
      expect_at(sc + 1, K_PERR_OE, 1'b0, dbad ? "R7" : "R10");
    end
    if (dbad && cl) expect_at(sc + 1, K_STAT, 1'b1, "R8");
    bus(1, 1, 1, 1, d, be, dp, 1'b0, cl);
    idle(3);
  endtask

  // Read burst of n phases, no wait states
  task automatic read_txn(logic [31:0] a, int n, bit cl);
    logic [31:0] d;
    logic [3:0]  be;
    expect_at(cyc + 1, K_PAR_OE, 1'b0, "R2");
    bus(0, 1, 1, 1, a, 4'b0110, 1'b0, 1'b1, cl);
    for (int k = 0; k < n; k++) begin
      d  = a ^ (32'h1357_9BDF * (k + 3));
      be = 4'(k * 5 + 2);
      expect_at(cyc + 1, K_PAR_OE, cl, cl ? "R1" : "R2");
      if (cl) expect_at(cyc + 1, K_PAR, epar(d, be), "R1");
      bus((k == n - 1), 0, 0, 0, d, be, (k == 0) ? epar(a, 4'b0110) : 1'b0, 1'b1, cl);
    end
    expect_at(cyc + 1, K_PAR_OE, 1'b0, "R2");
    expect_at(cyc + 1, K_SERR_OE, 1'b0, "R10");
    bus(1, 1, 1, 1, 32'h0, 4'hF, 1'b0, 1'b1, cl);
    idle(2);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: reset values
    check(par_oe_o, 1'b0, "R9", "par_oe");
    check(perr_oe_o, 1'b0, "R9", "perr_oe");
    check(serr_oe_o, 1'b0, "R9", "serr_oe");
    check(par_err_stat_o, 1'b0, "R9", "stat");
    check(perr_n_o, 1'b1, "R9", "perr_n");
    check(serr_n_o, 1'b1, "R9", "serr_n");
    rst = 1'b0;
    idle(2);

    // R10: clean write, clean write with waits
    write_txn(32'h1000_0040, 32'hA5A5_0F0F, 4'b0000, 0, 0, 1, 0);
    write_txn(32'h2000_0080, 32'h0123_4567, 4'b1100, 0, 0, 1, 2);
    check(par_err_stat_o, 1'b0, "R10", "stat after clean writes");

    // R1/R2: claimed burst read, unclaimed read
    read_txn(32'h3000_0100, 3, 1);
    read_txn(32'h4000_0200, 1, 0);

    // R5/R6: bad write data parity
    write_txn(32'h5000_0010, 32'hDEAD_BEEF, 4'b0000, 0, 1, 1, 0);
    // R8: clear strobe drops status
    clr_cycle = cyc + 1;
    idle(1);
    check(par_err_stat_o, 1'b0, "R8", "stat cleared");

    // R3/R4: bad address parity
    write_txn(32'h6000_0020, 32'h1111_2222, 4'b0000, 1, 0, 1, 0);
    clr_cycle = cyc + 1;
    idle(1);

    // R7: waits with bad parity, reported only at completion
    write_txn(32'h7000_0030, 32'h3333_4444, 4'b0011, 0, 1, 1, 2);
    clr_cycle = cyc + 1;
    idle(1);

    // R7: unclaimed bad data leaves status clear
    write_txn(32'h8000_0040, 32'h5555_6666, 4'b0000, 0, 1, 0, 0);
    check(par_err_stat_o, 1'b0, "R7", "stat after unclaimed");

    // R8: reporting disabled, status still set
    perr_en_i = 1'b0; serr_en_i = 1'b0;
    write_txn(32'h9000_0050, 32'h7777_8888, 4'b0000, 1, 1, 1, 0);
    check(par_err_stat_o, 1'b1, "R8", "stat with enables off");
    perr_en_i = 1'b1; serr_en_i = 1'b1;
    clr_cycle = cyc + 1;
    idle(1);
    check(par_err_stat_o, 1'b0, "R8", "stat cleared again");

    // R8: set wins over a clear in the same clock
    clr_cycle = cyc + 3;
    write_txn(32'hA000_0060, 32'h9999_AAAA, 4'b0000, 0, 1, 1, 0);
    check(par_err_stat_o, 1'b1, "R8", "set beats clear");

    idle(4);
    if (q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard leftover=%0d expected=0", q.size());
    end
    finish_run();
  end
endmodule